// File: doc/BRIEF.md
# Chained Active-Low Priority Encoder (16 to 4)

This block turns sixteen active-low request lines into the binary index of the most urgent request. Line 15 has the highest priority and line 0 the lowest. It is built from two identical 8-to-3 encoder cells. Each cell takes eight active-low requests and an active-low enable. It produces an active-low 3-bit index, an active-low "group has a request" flag and an enable output.

The cell for requests 15..8 sits at the head of the chain. Its enable output drives the enable of the cell for requests 7..0. As a result, the lower cell is only enabled while the upper cell is enabled and has no request. The two active-low indices are merged, and the upper cell's group flag gives the most significant code bit. The 4-bit code leaves the block active high.

The block has no storage, so every output follows the inputs within the same evaluation. An enable output is also brought out, so that a further block of the same kind can be chained below this one.

Top module: `prioCascade`

## Requirements
- R1: Request line i counts as asserted when `reqN[i]` is 0. The output `code` (active high) is the index of the highest-numbered asserted line.
- R2: While `enN` is 1, `code` is 0, `grpN` is 1 and `enOut` is 1, whatever the requests.
- R3: While `enN` is 0 and no request is asserted, `code` is 0, `grpN` is 1 and `enOut` is 0, so a following block is enabled.
- R4: While `enN` is 0 and any of lines 15..8 is asserted, `code` is 8 plus the highest asserted index in that range. Lines 7..0 have no effect on it.
- R5: While `enN` is 0, lines 15..8 are all released and any of lines 7..0 is asserted, `code` is the highest asserted index in 7..0.
- R6: While `enN` is 0, `grpN` is 0 exactly when at least one request is asserted. In that case `enOut` is 1.
- R7: `code[3]` is 1 exactly when the block is enabled and at least one of lines 15..8 is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reqN | input | 16 | Active-low request lines; bit 15 has the highest priority |
| enN | input | 1 | Active-low enable for the whole chain |
| code | output | 4 | Active-high index of the winning request |
| grpN | output | 1 | Active-low flag: some request is being encoded |
| enOut | output | 1 | Enable for a following block; low only when enabled with no request |

## Verification
The block is purely combinational, so an internal fault shows at the ports in the same evaluation as the stimulus that exposes it. Faults of this kind include a priority scan running the wrong way, a broken enable link between the cells, or a wrong merge of the indices. Because of this, exhaustive sweeps of each half against a bench model catch such faults. Each half is swept with the other half idle, and with both enable states. Random 16-bit patterns then exercise the case where both halves request at once. In that case the upper cell must silence the lower one.

// File: rtl/prioPkg.sv
package prioPkg;
  // Strobes from the enable/chain control to the index datapath of one cell.
  typedef struct packed {
    logic live;  // cell enabled
    logic hit;   // cell enabled and holding at least one request
  } cellStrobe_t;
endpackage

// File: rtl/prioPath.sv
module prioPath #(
  parameter int REQ_W = 8,
  localparam int IDX_W = $clog2(REQ_W)
) (
  input  logic [REQ_W-1:0]     reqN,
  input  prioPkg::cellStrobe_t strb,
  output logic                 anyReq,
  output logic [IDX_W-1:0]     codeN
);
  logic [IDX_W-1:0] topIdx;

  // Upward scan: a later (higher) asserted line overrides an earlier one.
  always_comb begin
    topIdx = '0;
    for (int i = 0; i < REQ_W; i++) begin
      if (!reqN[i]) topIdx = IDX_W'(i);
    end
  end

  assign anyReq = ~&reqN;
  assign codeN  = (strb.live && strb.hit) ? ~topIdx : '1;
endmodule

// File: rtl/prioCtl.sv
module prioCtl (
  input  logic                 enN,
  input  logic                 anyReq,
  output prioPkg::cellStrobe_t strb,
  output logic                 grpN,
  output logic                 enOut
);
  always_comb begin
    strb.live = !enN;
    strb.hit  = !enN && anyReq;
  end

  assign grpN  = !strb.hit;
  assign enOut = !(strb.live && !anyReq);
endmodule

// File: rtl/prioCell.sv
module prioCell #(
  parameter int REQ_W = 8,
  localparam int IDX_W = $clog2(REQ_W)
) (
  input  logic [REQ_W-1:0] reqN,
  input  logic             enN,
  output logic [IDX_W-1:0] codeN,
  output logic             grpN,
  output logic             enOut
);
  prioPkg::cellStrobe_t strb;
  logic                 anyReq;

  prioPath #(.REQ_W(REQ_W)) uPath (
    .reqN(reqN), .strb(strb), .anyReq(anyReq), .codeN(codeN)
  );

  prioCtl uCtl (
    .enN(enN), .anyReq(anyReq), .strb(strb), .grpN(grpN), .enOut(enOut)
  );
endmodule

// File: rtl/prioCascade.sv
module prioCascade #(
  parameter int LANE_W = 8,
  localparam int IDX_W  = $clog2(LANE_W),
  localparam int CODE_W = IDX_W + 1,
  localparam int REQ_W  = 2 * LANE_W
) (
  input  logic [REQ_W-1:0]  reqN,
  input  logic              enN,
  output logic [CODE_W-1:0] code,
  output logic              grpN,
  output logic              enOut
);
  // Index 1 is the upper (higher-priority) cell, index 0 the lower one.
  logic [IDX_W-1:0] cellCodeN [2];
  logic [1:0]       cellGrpN;
  logic [2:0]       chainEn;   // chainEn[2] feeds the upper cell

  assign chainEn[2] = enN;

  for (genvar c = 1; c >= 0; c--) begin : gCell
    prioCell #(.REQ_W(LANE_W)) uCell (
      .reqN (reqN[c*LANE_W +: LANE_W]),
      .enN  (chainEn[c+1]),
      .codeN(cellCodeN[c]),
      .grpN (cellGrpN[c]),
      .enOut(chainEn[c])
    );
  end

  assign code[IDX_W-1:0] = ~(cellCodeN[1] & cellCodeN[0]);
  assign code[IDX_W]     = ~cellGrpN[1];
  assign grpN            = &cellGrpN;
  assign enOut           = chainEn[0];
endmodule

// File: rtl/prioCascadeChk.sv
module prioCascadeChk #(
  parameter int LANE_W = 8,
  localparam int IDX_W  = $clog2(LANE_W),
  localparam int CODE_W = IDX_W + 1,
  localparam int REQ_W  = 2 * LANE_W
) (
  input logic [REQ_W-1:0]  reqN,
  input logic              enN,
  input logic [CODE_W-1:0] code,
  input logic              grpN,
  input logic              enOut
);
  always_comb begin
    AST_DISABLED_IDLE: assert (!enN || (code == '0 && grpN && enOut)); // R2
    AST_EMPTY_CHAIN: assert (enN || !(&reqN) || (code == '0 && grpN && !enOut)); // R3
    AST_GRP_TRACKS_REQ: assert (enN || (grpN == (&reqN))); // R6
    AST_EO_WHEN_HIT: assert (grpN || enOut); // R6
    AST_UPPER_BIT: assert (code[IDX_W] == (!enN && !(&reqN[REQ_W-1:LANE_W]))); // R7
    AST_TOP_LINE_WINS: assert (enN || reqN[REQ_W-1] || code == CODE_W'(REQ_W-1)); // R4
  end
endmodule

bind prioCascade prioCascadeChk #(.LANE_W(LANE_W)) uChk (
  .reqN(reqN), .enN(enN), .code(code), .grpN(grpN), .enOut(enOut)
);

// File: tb/sim_prioCascade.sv
module sim_prioCascade;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reqN = '1;
  logic        enN = 1'b1;
  logic [3:0]  code;
  logic        grpN;
  logic        enOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  prioCascade u0 (.reqN(reqN), .enN(enN), .code(code), .grpN(grpN), .enOut(enOut));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Bench model: {code, grpN, enOut} from the requirements.
  function automatic logic [5:0] model(input logic [15:0] r, input logic e);
    logic [3:0] idx = '0;
    logic any = 1'b0;
    for (int i = 0; i < 16; i++) if (!r[i]) begin idx = 4'(i); any = 1'b1; end
    if (e) return {4'd0, 1'b1, 1'b1};
    if (!any) return {4'd0, 1'b1, 1'b0};
    return {idx, 1'b0, 1'b1};
  endfunction

  task automatic apply(input logic [15:0] r, input logic e, input string req);
    logic [5:0] exp;
    reqN = r; enN = e;
    #1;
    exp = model(r, e);
    checks++;
    if ({code, grpN, enOut} !== exp) begin
      errors++;
      $display("FAIL %s: reqN=%h enN=%b actual code=%h grpN=%b enOut=%b expected code=%h grpN=%b enOut=%b",
               req, r, e, code, grpN, enOut, exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic testReset;  // R2 state at start
    apply(16'hFFFF, 1'b1, "R2 reset");
  endtask

  task automatic testDisabled;  // R2: sweep both halves while disabled
    for (int p = 0; p < 256; p++) begin
      apply({8'(p), 8'hFF}, 1'b1, "R2");
      apply({8'hFF, 8'(p)}, 1'b1, "R2");
    end
  endtask

  task automatic testEmpty;  // R3
    apply(16'hFFFF, 1'b0, "R3");
  endtask

  task automatic testUpper;  // R4, R6, R7: upper half sweep, lower idle and busy
    for (int p = 0; p < 256; p++) begin
      apply({8'(p), 8'hFF}, 1'b0, "R4_R7");
      apply({8'(p), 8'h00}, 1'b0, "R4");
    end
  endtask

  task automatic testLower;  // R5, R1, R6
    for (int p = 0; p < 256; p++) apply({8'hFF, 8'(p)}, 1'b0, "R5_R1");
  endtask

  task automatic testSingles;  // R1: one line at a time
    for (int i = 0; i < 16; i++) apply(~(16'h1 << i), 1'b0, "R1");
  endtask

  task automatic testRandom;  // R1, R4, R6 with both halves active
    for (int k = 0; k < 2000; k++) apply(16'($urandom), 1'($urandom & 1), "R1_R6");
  endtask

  initial begin
    #1;
    testReset();
    @(negedge clk); rst = 1'b0;
    testDisabled();
    testEmpty();
    testUpper();
    testLower();
    testSingles();
    testRandom();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule